// File: doc/BRIEF.md
# Ancillary Packet Deletion Filter

This block sits in the path of a 10-bit HD video ancillary data stream and removes chosen ancillary packets. It watches for the packet header, which is the three-word flag `0x000, 0x3FF, 0x3FF` followed by the DID word. When it has decided that a packet must go, it marks the packet for deletion. It does this by overwriting the DID word with `0x180` and regenerating the checksum word. The packet stays in place in the stream, so a later stage can reclaim the space.

Three small registers control the block. A control register has two bits. One is a master enable. The other selects between "remove everything" and "remove only designated packets". In designated mode an 8-bit mask picks which audio groups lose their data packets and which lose their control packets. A separate 8-bit DID register names one extra packet type to remove. Input words carry a valid qualifier. Only valid words advance the header detector and the packet parser. Gaps in valid are allowed anywhere.

The stream passes through a fixed two-cycle pipeline. Every word that enters, and its valid flag, appear at the output exactly two clock cycles later and in the same order.

Top module: `anc_pkt_filter`

## Requirements
- R1: After reset, all three registers read as 0 and no packet is altered. Register map: address 0 holds the enable (bit 1) and the mode select (bit 0). Address 1 holds the group mask. Address 2 holds the extra DID. Address 3 reads 0.
- R2: `out_valid` equals `in_valid` delayed by exactly two clock cycles. `out_data` carries the input word of that same cycle, possibly rewritten as described in the other requirements.
- R3: With the enable bit at 0, every word leaves the block unchanged, whatever the mode, mask and DID settings are.
- R4: With enable 1 and mode 0, every packet is deleted. Its DID word is output as `0x180`.
- R5: With enable 1 and mode 1, mask bits 7, 6, 5 and 4 delete audio data packets of groups 4, 3, 2 and 1. Those packets have DIDs 0xE4, 0xE5, 0xE6 and 0xE7 respectively.
- R6: With enable 1 and mode 1, mask bits 3, 2, 1 and 0 delete audio control packets of groups 4, 3, 2 and 1. Those packets have DIDs 0xE0, 0xE1, 0xE2 and 0xE3 respectively.
- R7: With enable 1 and mode 1, a packet whose DID (the low 8 bits of the DID word) equals the extra DID register is deleted.
- R8: Packets that are not selected pass unchanged. In a deleted packet, the flag, DBN, DC and user data words are unchanged.
- R9: A deleted packet's checksum word is rewritten. Its bits 8:0 are the 9-bit sum of bits 8:0 of the new DID word (`0x180`), DBN, DC and all user data words. Bit 9 is the inverse of bit 8.
- R10: The deletion decision uses the register values in force when the DID word is accepted. A write later in the same packet does not change how the rest of that packet is treated.
- R11: A header is recognised only when three consecutive valid words are `0x000, 0x3FF, 0x3FF`, and the fourth valid word is then taken as the DID. Invalid cycles between these words do not break the sequence. A broken flag sequence starts no packet.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 2 | Register address |
| reg_wdata | input | 8 | Register write data |
| reg_rdata | output | 8 | Register read data for `reg_addr` (combinational) |
| in_valid | input | 1 | Input word qualifier |
| in_data | input | 10 | Input ancillary stream word |
| out_valid | output | 1 | Output word qualifier |
| out_data | output | 10 | Output stream word |

## Verification
The embedded assertions check the following on every cycle:
- the two-cycle alignment of valid between input and output;
- that a word of a surviving packet reaches the output unchanged;
- that a deleted DID always leaves as `0x180`;
- that a rewritten checksum always has bit 9 opposite bit 8;
- that a header seen with the enable low never starts a deletion;
- that the registers change only on a write.

Other behaviours can only be shown by the bench's scenarios. These include the exact mapping from mask bits to audio DIDs, the match on the extra DID, the value of the regenerated checksum, header recognition across valid gaps, and the rejection of a broken flag. They also include the rule that a write in mid-packet leaves the current packet's treatment alone but governs the next one.

// File: rtl/afd_pkg.sv
// Shared constants, types and the audio-group lookup for the ancillary
// packet deletion filter. Assumes a 10-bit stream with 8-bit DIDs.
package afd_pkg;

    localparam int VID_W  = 10;
    localparam int DID_W  = 8;
    localparam int SUM_W  = 9;
    localparam int MASK_W = 8;

    localparam logic [VID_W-1:0] FLAG_LO  = '0;
    localparam logic [VID_W-1:0] FLAG_HI  = '1;
    localparam logic [VID_W-1:0] DEL_MARK = 10'h180;

    // Audio DIDs occupy 0xE0..0xE7: the upper five bits are fixed.
    localparam logic [4:0] AUD_DID_HI = 5'b11100;

    typedef enum logic [1:0] {
        ROLE_PASS,
        ROLE_DID,
        ROLE_BODY,
        ROLE_CSUM
    } afd_role_e;

    typedef enum logic [2:0] {
        PS_IDLE,
        PS_DBN,
        PS_DC,
        PS_UDW,
        PS_CSUM
    } afd_pstate_e;

    typedef struct packed {
        logic               enable;
        logic               mode;
        logic [MASK_W-1:0]  grp_mask;
        logic [DID_W-1:0]   xtra_did;
    } afd_cfg_t;

    // Returns the mask bit that governs an audio DID, 0 for any other DID.
    // Data DIDs 0xE7..0xE4 map to bits 4..7, control 0xE3..0xE0 to bits 0..3.
    function automatic logic afd_group_hit(input logic [DID_W-1:0]  did,
                                           input logic [MASK_W-1:0] mask);
        logic [3:0] sel;
        if (did[7:3] != AUD_DID_HI) begin
            return 1'b0;
        end
        if (did[2]) begin
            sel = 4'd11 - {1'b0, did[2:0]};
        end else begin
            sel = 4'd3 - {1'b0, did[2:0]};
        end
        return mask[sel[2:0]];
    endfunction

endpackage

// File: rtl/afd_cfg_regs.sv
// Control register file of the deletion filter. Three 8-bit locations,
// written by a single-cycle strobe, read back combinationally.
// Assumes writes are one word per cycle; unused addresses read 0.
module afd_cfg_regs
    import afd_pkg::*;
#(
    parameter int ADDR_W = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] addr,
    input  logic [7:0]        wdata,
    output logic [7:0]        rdata,
    output afd_cfg_t          cfg
);

    localparam logic [ADDR_W-1:0] A_CTRL = ADDR_W'(0);
    localparam logic [ADDR_W-1:0] A_MASK = ADDR_W'(1);
    localparam logic [ADDR_W-1:0] A_XDID = ADDR_W'(2);

    // Register update: reset clears everything, a strobe loads one location.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cfg <= '0;
        end else if (wr_en) begin
            case (addr)
                A_CTRL: begin
                    cfg.enable <= wdata[1];
                    cfg.mode   <= wdata[0];
                end
                A_MASK:  cfg.grp_mask <= wdata;
                A_XDID:  cfg.xtra_did <= wdata;
                default: ;
            endcase
        end
    end

    // Read mux: returns the addressed location.
    always_comb begin
        case (addr)
            A_CTRL:  rdata = {6'b0, cfg.enable, cfg.mode};
            A_MASK:  rdata = cfg.grp_mask;
            A_XDID:  rdata = cfg.xtra_did;
            default: rdata = '0;
        endcase
    end

    AST_CFG_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(wr_en) |-> $stable(cfg)); // R1

endmodule

// File: rtl/afd_del_decide.sv
// Pure decision logic: given the active configuration and a DID,
// says whether a packet carrying that DID must be deleted.
// Assumes the caller only consults the answer on a DID word.
module afd_del_decide
    import afd_pkg::*;
(
    input  afd_cfg_t         cfg,
    input  logic [DID_W-1:0] did,
    output logic             hit
);

    logic grp_hit;
    logic xtra_hit;

    // Designated-mode matches: audio group mask and the extra DID.
    always_comb begin
        grp_hit  = afd_group_hit(did, cfg.grp_mask);
        xtra_hit = (did == cfg.xtra_did);
    end

    // Mode selection: off, delete all, or delete designated only.
    always_comb begin
        if (!cfg.enable) begin
            hit = 1'b0;
        end else if (!cfg.mode) begin
            hit = 1'b1;
        end else begin
            hit = grp_hit | xtra_hit;
        end
    end

endmodule

// File: rtl/afd_hdr_parser.sv
// First pipeline stage. Tracks the last three valid words to spot the
// header flag, walks each packet through DBN, DC, user words and checksum,
// and tags every registered word with its role and the packet's verdict.
// Assumes well-formed packets; a new header restarts parsing at any time.
module afd_hdr_parser
    import afd_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             in_valid,
    input  logic [VID_W-1:0] in_data,
    input  logic             enable_now,
    input  logic             del_hit,
    output logic             s1_valid,
    output logic [VID_W-1:0] s1_data,
    output afd_role_e        s1_role,
    output logic             s1_del
);

    logic [VID_W-1:0] hist0;
    logic [VID_W-1:0] hist1;
    logic [VID_W-1:0] hist2;
    afd_pstate_e      pstate;
    logic [7:0]       udw_left;
    logic             pkt_del;
    logic             hdr_seen;
    afd_role_e        role_now;
    logic             del_now;

    // Header match on the three most recent valid words.
    always_comb begin
        hdr_seen = (hist2 == FLAG_LO) && (hist1 == FLAG_HI) && (hist0 == FLAG_HI);
    end

    // Role of the current input word and the verdict that applies to it.
    always_comb begin
        role_now = ROLE_PASS;
        if (hdr_seen) begin
            role_now = ROLE_DID;
        end else begin
            case (pstate)
                PS_DBN, PS_DC, PS_UDW: role_now = ROLE_BODY;
                PS_CSUM:               role_now = ROLE_CSUM;
                default:               role_now = ROLE_PASS;
            endcase
        end
        del_now = hdr_seen ? del_hit : pkt_del;
    end

    // History of valid words for header detection.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            hist0 <= '0;
            hist1 <= '0;
            hist2 <= '0;
        end else if (in_valid) begin
            hist0 <= in_data;
            hist1 <= hist0;
            hist2 <= hist1;
        end
    end

    // Packet walker: advances one step per valid word.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pstate   <= PS_IDLE;
            udw_left <= '0;
        end else if (in_valid) begin
            if (hdr_seen) begin
                pstate <= PS_DBN;
            end else begin
                case (pstate)
                    PS_DBN: pstate <= PS_DC;
                    PS_DC: begin
                        udw_left <= in_data[7:0];
                        pstate   <= (in_data[7:0] == 8'd0) ? PS_CSUM : PS_UDW;
                    end
                    PS_UDW: begin
                        udw_left <= udw_left - 8'd1;
                        if (udw_left == 8'd1) begin
                            pstate <= PS_CSUM;
                        end
                    end
                    PS_CSUM: pstate <= PS_IDLE;
                    default: pstate <= PS_IDLE;
                endcase
            end
        end
    end

    // Verdict latch: taken at the DID word, held to the checksum.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pkt_del <= 1'b0;
        end else if (in_valid) begin
            if (hdr_seen) begin
                pkt_del <= del_hit;
            end else if (pstate == PS_CSUM) begin
                pkt_del <= 1'b0;
            end
        end
    end

    // Stage register: word, qualifier, role and verdict move together.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            s1_valid <= 1'b0;
            s1_data  <= '0;
            s1_role  <= ROLE_PASS;
            s1_del   <= 1'b0;
        end else begin
            s1_valid <= in_valid;
            s1_data  <= in_data;
            s1_role  <= in_valid ? role_now : ROLE_PASS;
            s1_del   <= in_valid && (role_now != ROLE_PASS) && del_now;
        end
    end

    AST_OFF_NO_DEL: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && hdr_seen && !enable_now) |=> !s1_del); // R3

    AST_DID_AFTER_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
        (s1_valid && s1_role == ROLE_DID) |-> (hist1 == FLAG_HI)); // R11

endmodule

// File: rtl/afd_word_rewrite.sv
// Second pipeline stage. Accumulates the 9-bit checksum of a packet
// from its (possibly rewritten) DID onward, and substitutes the deletion
// mark and the new checksum for packets tagged for deletion.
// Assumes stage-one tags are consistent within a packet.
module afd_word_rewrite
    import afd_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             s1_valid,
    input  logic [VID_W-1:0] s1_data,
    input  afd_role_e        s1_role,
    input  logic             s1_del,
    output logic             out_valid,
    output logic [VID_W-1:0] out_data
);

    logic [SUM_W-1:0] sum_q;
    logic [VID_W-1:0] word_next;

    // Output word selection for the current stage-one word.
    always_comb begin
        word_next = s1_data;
        if (s1_del && s1_role == ROLE_DID) begin
            word_next = DEL_MARK;
        end else if (s1_del && s1_role == ROLE_CSUM) begin
            word_next = {~sum_q[SUM_W-1], sum_q};
        end
    end

    // Running checksum, restarted at each DID with the mark value.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sum_q <= '0;
        end else if (s1_valid) begin
            if (s1_role == ROLE_DID) begin
                sum_q <= DEL_MARK[SUM_W-1:0];
            end else if (s1_role == ROLE_BODY) begin
                sum_q <= sum_q + s1_data[SUM_W-1:0];
            end
        end
    end

    // Output register.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_valid <= 1'b0;
            out_data  <= '0;
        end else begin
            out_valid <= s1_valid;
            out_data  <= word_next;
        end
    end

    AST_MARK_DID: assert property (@(posedge clk) disable iff (!rst_n)
        (s1_valid && s1_role == ROLE_DID && s1_del) |=> (out_valid && out_data == DEL_MARK)); // R4

    AST_CSUM_PARITY: assert property (@(posedge clk) disable iff (!rst_n)
        (s1_valid && s1_role == ROLE_CSUM && s1_del) |=> (out_data[9] != out_data[8])); // R9

    AST_KEEP_WORD: assert property (@(posedge clk) disable iff (!rst_n)
        (s1_valid && !s1_del) |=> (out_data == $past(s1_data))); // R8

endmodule

// File: rtl/anc_pkt_filter.sv
// Top of the ancillary packet deletion filter: register file, decision
// logic and a two-stage pipeline (parse/tag, then rewrite).
// Assumes a continuous clock; input words qualified by in_valid.
module anc_pkt_filter
    import afd_pkg::*;
#(
    parameter int REG_AW = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              reg_wr,
    input  logic [REG_AW-1:0] reg_addr,
    input  logic [7:0]        reg_wdata,
    output logic [7:0]        reg_rdata,
    input  logic              in_valid,
    input  logic [VID_W-1:0]  in_data,
    output logic              out_valid,
    output logic [VID_W-1:0]  out_data
);

    afd_cfg_t         cfg;
    logic             del_hit;
    logic             s1_valid;
    logic [VID_W-1:0] s1_data;
    afd_role_e        s1_role;
    logic             s1_del;

    afd_cfg_regs #(.ADDR_W(REG_AW)) u_regs (
        .clk   (clk),
        .rst_n (rst_n),
        .wr_en (reg_wr),
        .addr  (reg_addr),
        .wdata (reg_wdata),
        .rdata (reg_rdata),
        .cfg   (cfg)
    );

    afd_del_decide u_decide (
        .cfg (cfg),
        .did (in_data[DID_W-1:0]),
        .hit (del_hit)
    );

    afd_hdr_parser u_parse (
        .clk        (clk),
        .rst_n      (rst_n),
        .in_valid   (in_valid),
        .in_data    (in_data),
        .enable_now (cfg.enable),
        .del_hit    (del_hit),
        .s1_valid   (s1_valid),
        .s1_data    (s1_data),
        .s1_role    (s1_role),
        .s1_del     (s1_del)
    );

    afd_word_rewrite u_rewrite (
        .clk       (clk),
        .rst_n     (rst_n),
        .s1_valid  (s1_valid),
        .s1_data   (s1_data),
        .s1_role   (s1_role),
        .s1_del    (s1_del),
        .out_valid (out_valid),
        .out_data  (out_data)
    );

    AST_VALID_ALIGN: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid == $past(in_valid, 2)); // R2

endmodule

// File: tb/anc_pkt_filter_test.sv
module anc_pkt_filter_test;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       reg_wr = 1'b0;
    logic [1:0] reg_addr = '0;
    logic [7:0] reg_wdata = '0;
    logic [7:0] reg_rdata;
    logic       in_valid = 1'b0;
    logic [9:0] in_data = '0;
    logic       out_valid;
    logic [9:0] out_data;

    int total = 0;
    int bad = 0;
    int cyc = 0;
    bit done = 0;

    // expected-item scoreboard
    logic [9:0] q_data[$];
    int         q_due[$];
    string      q_tag[$];

    // bench copy of the configuration
    bit       b_en = 0;
    bit       b_mode = 0;
    bit [7:0] b_mask = 0;
    bit [7:0] b_xdid = 0;

    // pending register write riding on the next stream word
    bit       pend_wr = 0;
    bit [1:0] pend_addr = 0;
    bit [7:0] pend_data = 0;

    anc_pkt_filter uut (
        .clk       (clk),
        .rst_n     (rst_n),
        .reg_wr    (reg_wr),
        .reg_addr  (reg_addr),
        .reg_wdata (reg_wdata),
        .reg_rdata (reg_rdata),
        .in_valid  (in_valid),
        .in_data   (in_data),
        .out_valid (out_valid),
        .out_data  (out_data)
    );

    always #5 clk = ~clk;

    always @(posedge clk) cyc <= cyc + 1;

    task automatic check(input string tag, input logic [9:0] got, input logic [9:0] exp);
        total++;
        if (got !== exp) begin
            bad++;
            $display("FAIL %s: got %h expected %h", tag, got, exp);
        end
    endtask

    // Monitor: pops expected words as output words appear.
    always @(negedge clk) begin
        if (rst_n && !done && out_valid) begin
            total++;
            if (q_data.size() == 0) begin
                bad++;
                $display("FAIL R2: unexpected output word %h, expected none", out_data);
            end else begin
                logic [9:0] e;
                int d;
                string t;
                e = q_data.pop_front();
                d = q_due.pop_front();
                t = q_tag.pop_front();
                if (out_data !== e || d != cyc) begin
                    bad++;
                    $display("FAIL %s: got %h at cycle %0d, expected %h at cycle %0d",
                             t, out_data, cyc, e, d);
                end
            end
        end
    end

    // Watchdog
    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            done = 1;
            total++;
            bad++;
            $display("FAIL watchdog: got timeout, expected completion");
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    function automatic bit exp_del(input bit [7:0] did);
        bit g;
        if (!b_en) return 0;
        if (!b_mode) return 1;
        case (did)
            8'hE7: g = b_mask[4];
            8'hE6: g = b_mask[5];
            8'hE5: g = b_mask[6];
            8'hE4: g = b_mask[7];
            8'hE3: g = b_mask[0];
            8'hE2: g = b_mask[1];
            8'hE1: g = b_mask[2];
            8'hE0: g = b_mask[3];
            default: g = 0;
        endcase
        return g || (did == b_xdid);
    endfunction

    task automatic drive(input logic [9:0] w, input logic [9:0] e, input string tag);
        @(negedge clk);
        in_valid = 1'b1;
        in_data  = w;
        if (pend_wr) begin
            reg_wr    = 1'b1;
            reg_addr  = pend_addr;
            reg_wdata = pend_data;
            pend_wr   = 0;
        end else begin
            reg_wr = 1'b0;
        end
        q_data.push_back(e);
        q_due.push_back(cyc + 2);
        q_tag.push_back(tag);
    endtask

    task automatic idle(input int n);
        repeat (n) begin
            @(negedge clk);
            in_valid = 1'b0;
            reg_wr   = 1'b0;
        end
    endtask

    task automatic reg_write(input bit [1:0] a, input bit [7:0] d);
        @(negedge clk);
        in_valid  = 1'b0;
        reg_wr    = 1'b1;
        reg_addr  = a;
        reg_wdata = d;
        @(negedge clk);
        reg_wr = 1'b0;
        if (a == 0) begin b_en = d[1]; b_mode = d[0]; end
        if (a == 1) b_mask = d;
        if (a == 2) b_xdid = d;
    endtask

    // One packet; expected words built from the packet and bench config.
    task automatic send_packet(input bit [7:0] did, input int dc, input int base,
                               input bit gap, input bit mid_wr, input bit [7:0] mid_ctrl,
                               input string tag);
        bit del;
        logic [9:0] didw, dcw, u, csin;
        logic [8:0] s_new, s_org;
        del  = exp_del(did);
        didw = {2'b10, did};
        dcw  = {2'b10, 8'(dc)};
        drive(10'h000, 10'h000, tag); if (gap) idle(1);
        drive(10'h3FF, 10'h3FF, tag); if (gap) idle(1);
        drive(10'h3FF, 10'h3FF, tag); if (gap) idle(1);
        drive(didw, del ? 10'h180 : didw, tag); if (gap) idle(1);
        s_new = 9'h180;
        s_org = didw[8:0];
        if (mid_wr) begin
            pend_wr = 1; pend_addr = 0; pend_data = mid_ctrl;
        end
        drive(10'h111, 10'h111, tag); if (gap) idle(1);
        s_new += 9'h111; s_org += 9'h111;
        drive(dcw, dcw, tag); if (gap) idle(1);
        s_new += dcw[8:0]; s_org += dcw[8:0];
        for (int i = 0; i < dc; i++) begin
            u = 10'h040 + 10'((base + i * 37) % 768);
            drive(u, u, tag); if (gap) idle(1);
            s_new += u[8:0]; s_org += u[8:0];
        end
        csin = {~s_org[8], s_org};
        drive(csin, del ? {~s_new[8], s_new} : csin, tag);
        idle(1);
        if (mid_wr) begin b_en = mid_ctrl[1]; b_mode = mid_ctrl[0]; end
    endtask

    task automatic read_reg(input bit [1:0] a, input logic [7:0] exp, input string tag);
        @(negedge clk);
        reg_addr = a;
        #1;
        check(tag, {2'b00, reg_rdata}, {2'b00, exp});
    endtask

    initial begin
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1: reset state of registers and output
        read_reg(2'd0, 8'h00, "R1 ctrl");
        read_reg(2'd1, 8'h00, "R1 mask");
        read_reg(2'd2, 8'h00, "R1 xdid");
        read_reg(2'd3, 8'h00, "R1 unused");
        check("R1 out_valid", {9'b0, out_valid}, 10'b0);
        send_packet(8'hE7, 3, 5, 0, 0, 0, "R1 default pass");

        // R3: disabled but other settings primed
        reg_write(2'd1, 8'hFF);
        reg_write(2'd2, 8'h45);
        reg_write(2'd0, 8'h01);
        read_reg(2'd1, 8'hFF, "R1 mask readback");
        send_packet(8'hE4, 2, 9, 0, 0, 0, "R3 disabled");
        send_packet(8'h45, 1, 3, 0, 0, 0, "R3 disabled xdid");

        // R4/R9: delete all, with DC=0 and with gaps (R11)
        reg_write(2'd0, 8'h02);
        send_packet(8'h45, 4, 11, 0, 0, 0, "R4 delete all");
        send_packet(8'h12, 0, 0, 0, 0, 0, "R9 dc zero");
        send_packet(8'h99, 5, 40, 1, 0, 0, "R11 gapped header");

        // R11: broken flag sequence starts no packet
        drive(10'h000, 10'h000, "R11 broken flag");
        drive(10'h3FF, 10'h3FF, "R11 broken flag");
        drive(10'h155, 10'h155, "R11 broken flag");
        drive(10'h3FF, 10'h3FF, "R11 broken flag");
        drive(10'h2E7, 10'h2E7, "R11 broken flag");
        drive(10'h111, 10'h111, "R11 broken flag");
        idle(2);

        // R5: data groups 4 and 1 only
        reg_write(2'd1, 8'h90);
        reg_write(2'd2, 8'h00);
        reg_write(2'd0, 8'h03);
        send_packet(8'hE4, 2, 1, 0, 0, 0, "R5 group4 data");
        send_packet(8'hE7, 2, 2, 0, 0, 0, "R5 group1 data");
        send_packet(8'hE5, 2, 3, 0, 0, 0, "R5 group3 data kept");
        send_packet(8'hE6, 2, 4, 0, 0, 0, "R5 group2 data kept");
        send_packet(8'hE0, 1, 4, 0, 0, 0, "R6 control kept");

        // R6: control groups 1 and 3
        reg_write(2'd1, 8'h05);
        send_packet(8'hE3, 3, 7, 0, 0, 0, "R6 group1 ctrl");
        send_packet(8'hE1, 1, 8, 0, 0, 0, "R6 group3 ctrl");
        send_packet(8'hE2, 2, 9, 0, 0, 0, "R6 group2 ctrl kept");
        send_packet(8'hE7, 2, 9, 0, 0, 0, "R5 data kept");

        // R7/R8: extra DID
        reg_write(2'd1, 8'h00);
        reg_write(2'd2, 8'h61);
        send_packet(8'h61, 6, 21, 0, 0, 0, "R7 extra did");
        send_packet(8'h62, 6, 22, 0, 0, 0, "R8 other kept");

        // R10: mid-packet disable does not rescue the current packet
        reg_write(2'd0, 8'h02);
        send_packet(8'h33, 4, 50, 0, 1, 8'h00, "R10 mid write");
        send_packet(8'h33, 4, 51, 0, 0, 0, "R10 next packet");
        read_reg(2'd0, 8'h00, "R10 ctrl after write");

        idle(6);
        total++;
        if (q_data.size() != 0) begin
            bad++;
            $display("FAIL R2: got %0d words pending, expected 0", q_data.size());
        end
        done = 1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule